// File: doc/BRIEF.md
# Serially Loaded Multichannel Transmit Pulse Sequencer

This block sits between a single serial configuration line and a bank of transmit pulse drivers. A complete firing profile is shifted in one bit per clock: a check header, a receive gain code, a burst length, a start hold-off and, for every channel, a start delay and a pulse width. A latch request opens the profile only when the header reads all ones. A shared elapsed-time counter then advances once per clock tick, and every channel emits its own burst of equal-width pulses at its own delay.

The elapsed count is formed from a 6-bit coarse part that counts down from all ones and a 5-bit fine part that wraps every 32 ticks, which gives an 11-bit reach of 0 to 2047 ticks. While one profile fires, the next may already be shifted into the serial chain: the chain and the active profile are separate storage. A completion flag tells the system that every channel has finished its burst, and the receive gain code is held at an output from one accepted latch to the next.

Top module: `tx_delay_sequencer`

## Requirements
- R1: After reset all pulse outputs, the error flag, the completion flag and the gain output are 0.
- R2: With `serValid` high each clock shifts `serData` into the chain, first bit first. After the full packet of 16·NCH+16 bits, the first six bits form the header. The next bits, most significant bit first, hold the 2-bit gain, the 3-bit burst code, and then the 5-bit hold-off. Last come the channel slots, channel 0 first and channel NCH−1 last. Each slot carries an 11-bit delay followed by a 5-bit width code.
- R3: A latch request while idle or finished, with a header other than 111111, sets `loadError`. It loads nothing, produces no pulses, and leaves `fireDone` low. An accepted latch clears `loadError`.
- R4: `clearShift` zeroes the entire chain, so a latch request without new data afterwards is rejected as in R3.
- R5: After an accepted latch the elapsed count waits the hold-off value `p` in clock ticks before it starts from zero.
- R6: Counting the accepting clock edge as edge 0, channel i goes high after edge 2 + p + delay_i.
- R7: Each pulse lasts width code + 1 ticks and is followed by a low gap of the same length. A burst code n gives n + 1 pulses (1 to 8).
- R8: The elapsed count reaches every delay from 0 to 2047, including 2047 itself.
- R9: `fireDone` rises after edge max(2049 + p, last falling edge of any channel + 1). It stays high with all pulses low until the next latch request.
- R10: `rxGain` takes the packet's gain field at an accepted latch and holds it at all other times.
- R11: Shifting, clearing the chain or requesting a latch while a profile is holding off or firing leaves that profile's pulses and the gain output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| clearShift | input | 1 | Zeroes the serial chain |
| serValid | input | 1 | Shift enable for the serial chain |
| serData | input | 1 | Serial profile bit |
| latchReq | input | 1 | Request to check and open the loaded profile |
| txPulse | output | NCH | Per-channel low-voltage transmit pulse |
| rxGain | output | 2 | Receive gain code from the last accepted profile |
| loadError | output | 1 | Last latch request failed the header check |
| fireDone | output | 1 | All channel bursts of the active profile are finished |

## Verification
On every cycle the assertions check the following: a rejected header keeps every pulse low and the completion flag clear; the gain code moves only at a latch request; completion is sticky until the next request, with all outputs quiet while it holds; and completion never rises straight after an active pulse. The exact start edges, widths, gaps and burst lengths, the hold-off, the 2047-tick reach and the undisturbed firing while the next packet is shifted in depend on per-channel profile values. The directed scenarios show those, comparing every channel on every cycle against a timing model built from the requirements.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    CH_ARMED    = 2'd0,
    CH_HIGH     = 2'd1,
    CH_LOW      = 2'd2,
    CH_FINISHED = 2'd3
  } chanState_t;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic loadActive;    // copy chain fields into the active profile
    logic counterClear;  // return elapsed count to zero
    logic counterStep;   // advance elapsed count one tick
    logic runEnable;     // channels may compare and start
  } seqStrobe_t;

endpackage

// File: rtl/tx_seq_counter.sv
module tx_seq_counter #(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5,
  localparam int TICK_W  = COARSE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              step,
  output logic [TICK_W-1:0] tick,
  output logic              atEnd
);

  localparam logic [COARSE_W-1:0] COARSE_TOP = '1;
  localparam logic [FINE_W-1:0]   FINE_TOP   = '1;

  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;

  assign atEnd = (coarse == '0) && (fine == FINE_TOP);
  // Coarse counts down, so its complement is the elapsed coarse index
  assign tick  = {~coarse, fine};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarse <= COARSE_TOP;
      fine   <= '0;
    end else if (clear) begin
      coarse <= COARSE_TOP;
      fine   <= '0;
    end else if (step && !atEnd) begin
      if (fine == FINE_TOP) begin
        fine   <= '0;
        coarse <= coarse - 1'b1;
      end else begin
        fine <= fine + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_seq_channel.sv
module tx_seq_channel
  import tx_seq_pkg::*;
#(
  parameter int DELAY_W = 11,
  parameter int WIDTH_W = 5,
  parameter int BURST_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               arm,
  input  logic               runEnable,
  input  logic [DELAY_W-1:0] tick,
  input  logic [DELAY_W-1:0] delayVal,
  input  logic [WIDTH_W-1:0] widthVal,
  input  logic [BURST_W-1:0] burstVal,
  output logic               pulse,
  output logic               finished
);

  chanState_t         state;
  logic [WIDTH_W-1:0] phaseCnt;
  logic [BURST_W-1:0] pulsesLeft;

  assign pulse    = (state == CH_HIGH);
  assign finished = (state == CH_FINISHED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= CH_ARMED;
      phaseCnt   <= '0;
      pulsesLeft <= '0;
    end else if (arm) begin
      state      <= CH_ARMED;
      phaseCnt   <= '0;
      pulsesLeft <= '0;
    end else begin
      unique case (state)
        CH_ARMED: begin
          if (runEnable && (tick == delayVal)) begin
            state      <= CH_HIGH;
            phaseCnt   <= widthVal;
            pulsesLeft <= burstVal;
          end
        end
        CH_HIGH: begin
          if (phaseCnt == '0) begin
            if (pulsesLeft == '0) begin
              state <= CH_FINISHED;
            end else begin
              state    <= CH_LOW;
              phaseCnt <= widthVal;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        CH_LOW: begin
          if (phaseCnt == '0) begin
            state      <= CH_HIGH;
            phaseCnt   <= widthVal;
            pulsesLeft <= pulsesLeft - 1'b1;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= CH_FINISHED;
      endcase
    end
  end

endmodule

// File: rtl/tx_seq_datapath.sv
module tx_seq_datapath
  import tx_seq_pkg::*;
#(
  parameter int NCH      = 64,
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5,
  parameter int WIDTH_W  = 5,
  parameter int BURST_W  = 3,
  parameter int GAIN_W   = 2,
  parameter int HOLD_W   = 5,
  parameter int HDR_W    = 6,
  localparam int DELAY_W = COARSE_W + FINE_W,
  localparam int SLOT_W  = DELAY_W + WIDTH_W,
  localparam int PKT_W   = NCH * SLOT_W + HDR_W + GAIN_W + BURST_W + HOLD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearShift,
  input  logic              serValid,
  input  logic              serData,
  input  seqStrobe_t        strobe,
  output logic              headerOk,
  output logic [HOLD_W-1:0] pendingHold,
  output logic              atEnd,
  output logic              allFinished,
  output logic [NCH-1:0]    txPulse,
  output logic [GAIN_W-1:0] rxGain
);

  // Field positions inside the chain, first shifted bit at the top
  localparam int HDR_LSB   = PKT_W - HDR_W;
  localparam int GAIN_LSB  = HDR_LSB - GAIN_W;
  localparam int BURST_LSB = GAIN_LSB - BURST_W;
  localparam int HOLD_LSB  = BURST_LSB - HOLD_W;

  logic [PKT_W-1:0]   chain;
  logic [DELAY_W-1:0] actDelay [NCH];
  logic [WIDTH_W-1:0] actWidth [NCH];
  logic [BURST_W-1:0] actBurst;
  logic [GAIN_W-1:0]  actGain;
  logic [DELAY_W-1:0] tick;
  logic [NCH-1:0]     finVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else if (clearShift) begin
      chain <= '0;
    end else if (serValid) begin
      chain <= {chain[PKT_W-2:0], serData};
    end
  end

  assign headerOk    = (chain[HDR_LSB +: HDR_W] == {HDR_W{1'b1}});
  assign pendingHold = chain[HOLD_LSB +: HOLD_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actBurst <= '0;
      actGain  <= '0;
      for (int i = 0; i < NCH; i++) begin
        actDelay[i] <= '0;
        actWidth[i] <= '0;
      end
    end else if (strobe.loadActive) begin
      actBurst <= chain[BURST_LSB +: BURST_W];
      actGain  <= chain[GAIN_LSB +: GAIN_W];
      for (int i = 0; i < NCH; i++) begin
        actDelay[i] <= chain[(NCH-1-i)*SLOT_W + WIDTH_W +: DELAY_W];
        actWidth[i] <= chain[(NCH-1-i)*SLOT_W +: WIDTH_W];
      end
    end
  end

  assign rxGain = actGain;

  tx_seq_counter #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W)
  ) u_counter (
    .clk  (clk),
    .rstN (rstN),
    .clear(strobe.counterClear),
    .step (strobe.counterStep),
    .tick (tick),
    .atEnd(atEnd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tx_seq_channel #(
      .DELAY_W(DELAY_W),
      .WIDTH_W(WIDTH_W),
      .BURST_W(BURST_W)
    ) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .arm      (strobe.loadActive),
      .runEnable(strobe.runEnable),
      .tick     (tick),
      .delayVal (actDelay[g]),
      .widthVal (actWidth[g]),
      .burstVal (actBurst),
      .pulse    (txPulse[g]),
      .finished (finVec[g])
    );
  end

  assign allFinished = &finVec;

endmodule

// File: rtl/tx_seq_control.sv
module tx_seq_control
  import tx_seq_pkg::*;
#(
  parameter int HOLD_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchReq,
  input  logic              headerOk,
  input  logic [HOLD_W-1:0] pendingHold,
  input  logic              atEnd,
  input  logic              allFinished,
  output seqStrobe_t        strobe,
  output logic              loadError,
  output logic              fireDone
);

  seqState_t         state;
  logic [HOLD_W-1:0] holdCnt;
  logic              canLatch;
  logic              acceptLatch;
  logic              rejectLatch;

  assign canLatch    = (state == ST_IDLE) || (state == ST_DONE);
  assign acceptLatch = canLatch && latchReq && headerOk;
  assign rejectLatch = canLatch && latchReq && !headerOk;

  always_comb begin
    strobe              = '0;
    strobe.loadActive   = acceptLatch;
    strobe.counterClear = acceptLatch;
    strobe.counterStep  = (state == ST_RUN);
    strobe.runEnable    = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      holdCnt   <= '0;
      loadError <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (acceptLatch) begin
            state     <= ST_HOLD;
            holdCnt   <= pendingHold;
            loadError <= 1'b0;
          end else if (rejectLatch) begin
            state     <= ST_IDLE;
            loadError <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (holdCnt == '0) begin
            state <= ST_RUN;
          end else begin
            holdCnt <= holdCnt - 1'b1;
          end
        end
        ST_RUN: begin
          if (atEnd && allFinished) begin
            state <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fireDone = (state == ST_DONE);

endmodule

// File: rtl/tx_delay_sequencer.sv
module tx_delay_sequencer
  import tx_seq_pkg::*;
#(
  parameter int NCH      = 64,
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5,
  parameter int WIDTH_W  = 5,
  parameter int BURST_W  = 3,
  parameter int GAIN_W   = 2,
  parameter int HOLD_W   = 5,
  parameter int HDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearShift,
  input  logic              serValid,
  input  logic              serData,
  input  logic              latchReq,
  output logic [NCH-1:0]    txPulse,
  output logic [GAIN_W-1:0] rxGain,
  output logic              loadError,
  output logic              fireDone
);

  seqStrobe_t        strobe;
  logic              headerOk;
  logic [HOLD_W-1:0] pendingHold;
  logic              atEnd;
  logic              allFinished;

  tx_seq_control #(
    .HOLD_W(HOLD_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .latchReq   (latchReq),
    .headerOk   (headerOk),
    .pendingHold(pendingHold),
    .atEnd      (atEnd),
    .allFinished(allFinished),
    .strobe     (strobe),
    .loadError  (loadError),
    .fireDone   (fireDone)
  );

  tx_seq_datapath #(
    .NCH     (NCH),
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W),
    .WIDTH_W (WIDTH_W),
    .BURST_W (BURST_W),
    .GAIN_W  (GAIN_W),
    .HOLD_W  (HOLD_W),
    .HDR_W   (HDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .clearShift (clearShift),
    .serValid   (serValid),
    .serData    (serData),
    .strobe     (strobe),
    .headerOk   (headerOk),
    .pendingHold(pendingHold),
    .atEnd      (atEnd),
    .allFinished(allFinished),
    .txPulse    (txPulse),
    .rxGain     (rxGain)
  );

endmodule

// File: rtl/tx_seq_checker.sv
module tx_seq_checker #(
  parameter int NCH    = 64,
  parameter int GAIN_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              latchReq,
  input logic [NCH-1:0]    txPulse,
  input logic [GAIN_W-1:0] rxGain,
  input logic              loadError,
  input logic              fireDone
);

  // R3: a rejected profile fires nothing and never completes
  assert_quiet_on_error_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadError |-> (txPulse == '0) && !fireDone);

  // R10: gain output changes only in answer to a latch request
  assert_gain_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !latchReq |=> $stable(rxGain));

  // R9: completion holds until the next request
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fireDone && !latchReq) |=> fireDone);

  // R9: no channel is driving while completion is shown
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    fireDone |-> (txPulse == '0));

  // R9: completion comes only after every pulse has ended
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fireDone) |-> ($past(txPulse) == '0));

endmodule

bind tx_delay_sequencer tx_seq_checker #(
  .NCH   (NCH),
  .GAIN_W(GAIN_W)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .latchReq (latchReq),
  .txPulse  (txPulse),
  .rxGain   (rxGain),
  .loadError(loadError),
  .fireDone (fireDone)
);

// File: tb/tx_delay_sequencer_test.sv
module tx_delay_sequencer_test;

  localparam int NCH   = 64;
  localparam int PKT_W = NCH * 16 + 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           clearShift = 1'b0;
  logic           serValid = 1'b0;
  logic           serData = 1'b0;
  logic           latchReq = 1'b0;
  logic [NCH-1:0] txPulse;
  logic [1:0]     rxGain;
  logic           loadError;
  logic           fireDone;

  int checks = 0;
  int fails  = 0;

  logic [10:0] dly [NCH];
  logic [4:0]  wid [NCH];
  int burstN, holdP, gainV;

  always #4 clk = ~clk;

  tx_delay_sequencer #(.NCH(NCH)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .clearShift(clearShift),
    .serValid  (serValid),
    .serData   (serData),
    .latchReq  (latchReq),
    .txPulse   (txPulse),
    .rxGain    (rxGain),
    .loadError (loadError),
    .fireDone  (fireDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PKT_W-1:0] buildPkt(input logic [5:0] hdr);
    logic [PKT_W-1:0] p;
    p = '0;
    p[PKT_W-1 -: 6]  = hdr;
    p[PKT_W-7 -: 2]  = gainV[1:0];
    p[PKT_W-9 -: 3]  = burstN[2:0];
    p[PKT_W-12 -: 5] = holdP[4:0];
    for (int i = 0; i < NCH; i++) p[(NCH-1-i)*16 +: 16] = {dly[i], wid[i]};
    return p;
  endfunction

  function automatic bit expPulse(input int ch, input int k);
    int s;
    for (int j = 0; j <= burstN; j++) begin
      s = 2 + holdP + int'(dly[ch]) + j * 2 * (int'(wid[ch]) + 1);
      if (k >= s && k <= s + int'(wid[ch])) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int expDoneK();
    int m, last;
    m = 2049 + holdP;
    for (int i = 0; i < NCH; i++) begin
      last = 2 + holdP + int'(dly[i]) + burstN * 2 * (int'(wid[i]) + 1) + int'(wid[i]);
      if (last + 2 > m) m = last + 2;
    end
    return m;
  endfunction

  // Entered just after a falling edge; leaves just after a falling edge
  task automatic shiftPkt(input logic [PKT_W-1:0] p);
    clearShift = 1'b1;
    @(negedge clk);
    clearShift = 1'b0;
    serValid = 1'b1;
    for (int b = PKT_W - 1; b >= 0; b--) begin
      serData = p[b];
      @(negedge clk);
    end
    serValid = 1'b0;
    serData  = 1'b0;
  endtask

  // Latches and compares every channel on every cycle until completion
  task automatic fireAndCheck(input string tag);
    int doneK, badPulse, badDone, firstK;
    logic [NCH-1:0] expVec, firstAct, firstExp;
    doneK = expDoneK();
    badPulse = 0; badDone = 0; firstK = -1;
    firstAct = '0; firstExp = '0;
    latchReq = 1'b1;
    @(negedge clk);
    latchReq = 1'b0;
    for (int k = 1; k <= doneK + 2; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) expVec[c] = expPulse(c, k);
      if (txPulse !== expVec) begin
        badPulse++;
        if (firstK < 0) begin firstK = k; firstAct = txPulse; firstExp = expVec; end
      end
      if (fireDone !== (k >= doneK)) badDone++;
      if (k == 1) check(loadError == 1'b0, "R3", {tag, " error cleared by accepted latch"}, loadError, 0);
    end
    if (firstK >= 0) $display("  %s first pulse mismatch at edge %0d: %h vs %h", tag, firstK, firstAct, firstExp);
    check(badPulse == 0, "R6", {tag, " per-channel start edges and pattern"}, badPulse, 0);
    check(badPulse == 0, "R7", {tag, " widths, gaps and burst length"}, badPulse, 0);
    check(badDone == 0, "R9", {tag, " completion edge"}, badDone, 0);
    check(rxGain == gainV[1:0], "R10", {tag, " gain taken at latch"}, rxGain, gainV);
  endtask

  task automatic t_reset();
    check(txPulse == '0, "R1", "pulses after reset", txPulse, 0);
    check(loadError == 1'b0 && fireDone == 1'b0, "R1", "flags after reset", {loadError, fireDone}, 0);
    check(rxGain == 2'd0, "R1", "gain after reset", rxGain, 0);
  endtask

  task automatic t_bad_header();
    int seen;
    for (int i = 0; i < NCH; i++) begin dly[i] = 11'(i); wid[i] = 5'd1; end
    burstN = 0; holdP = 0; gainV = 3;
    shiftPkt(buildPkt(6'b111011));
    latchReq = 1'b1;
    @(negedge clk);
    latchReq = 1'b0;
    seen = 0;
    for (int k = 0; k < 120; k++) begin
      if (txPulse != '0 || fireDone) seen++;
      @(negedge clk);
    end
    check(loadError == 1'b1, "R3", "mismatched header flags error", loadError, 1);
    check(seen == 0, "R3", "no pulses or completion after rejection", seen, 0);
    check(rxGain == 2'd0, "R3", "gain not loaded on rejection", rxGain, 0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < NCH; i++) begin dly[i] = 11'(i * 3); wid[i] = 5'(i % 4); end
    burstN = 0; holdP = 0; gainV = 2;
    shiftPkt(buildPkt(6'b111111));
    // R2 and R8: correct pulses prove the field layout and count span
    fireAndCheck("R2 basic profile");
  endtask

  task automatic t_burst_hold();
    for (int i = 0; i < NCH; i++) begin dly[i] = 11'((i * 7) % 50); wid[i] = 5'(i % 3); end
    wid[5] = 5'd31;
    burstN = 3; holdP = 5; gainV = 1;
    shiftPkt(buildPkt(6'b111111));
    fireAndCheck("R5 hold-off with four-pulse burst");
  endtask

  task automatic t_max_delay();
    for (int i = 0; i < NCH; i++) begin dly[i] = 11'd0; wid[i] = 5'd0; end
    dly[0] = 11'd2047;
    burstN = 0; holdP = 0; gainV = 3;
    shiftPkt(buildPkt(6'b111111));
    fireAndCheck("R8 delay 2047");
  endtask

  task automatic t_reload_while_firing();
    logic [PKT_W-1:0] pktB;
    for (int i = 0; i < NCH; i++) begin dly[i] = 11'(NCH - 1 - i); wid[i] = 5'd2; end
    burstN = 1; holdP = 3; gainV = 2;
    pktB = buildPkt(6'b111111);
    for (int i = 0; i < NCH; i++) begin dly[i] = 11'(i * 2); wid[i] = 5'd1; end
    burstN = 7; holdP = 2; gainV = 0;
    shiftPkt(buildPkt(6'b111111));
    fork
      fireAndCheck("R11 eight-pulse burst with load in flight");
      begin
        repeat (20) @(negedge clk);
        shiftPkt(pktB);
        repeat (30) @(negedge clk);
        latchReq = 1'b1;
        @(negedge clk);
        latchReq = 1'b0;
      end
    join
    for (int i = 0; i < NCH; i++) begin dly[i] = 11'(NCH - 1 - i); wid[i] = 5'd2; end
    burstN = 1; holdP = 3; gainV = 2;
    fireAndCheck("R11 profile shifted during firing");
  endtask

  task automatic t_clear();
    int seen;
    clearShift = 1'b1;
    @(negedge clk);
    clearShift = 1'b0;
    latchReq = 1'b1;
    @(negedge clk);
    latchReq = 1'b0;
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      if (txPulse != '0 || fireDone) seen++;
      @(negedge clk);
    end
    check(loadError == 1'b1, "R4", "latch after clear is rejected", loadError, 1);
    check(seen == 0, "R4", "no firing after clear", seen, 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_header();
    t_basic();
    t_burst_hold();
    t_max_delay();
    t_reload_while_firing();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule